// File: doc/BRIEF.md
# Serial Character Transmitter with Pin Steering

This block turns 8-bit characters into an asynchronous serial frame on a single output pin. Characters are pulled from an external first-in first-out store through a pop strobe; the block drives one low start bit, the eight data bits least significant first, an optional parity bit and one high stop bit. Every bit lasts sixteen pulses of a shared oversampling tick supplied from outside, so the bit rate is set entirely by that tick.

The output pin passes through a registered priority selector. A software override forces the pin to a chosen level. Line loopback copies the incoming receive level straight onto the pin. System loopback parks the pin high while the serial stream stays visible on a separate internal output meant for the local receiver. Two status flags are kept: an empty flag that follows the store's empty input, and an idle flag that rises only once the store is empty and the stop bit of the last character has been fully sent.

Top module: `uart_tx_path`

## Requirements
- R1: After reset `tx_pin` is 1, `tx_idle` is 1, `tx_empty` is 1 and `fifo_pop` is 0.
- R2: With parity off, a frame on the pin is one 0 start bit, then the eight data bits of the popped character with bit 0 first, then one 1 stop bit, and nothing else between frames but 1.
- R3: With `parity_en` set, one parity bit follows bit 7: with `parity_odd` = 0 it makes the count of ones over data plus parity even, with `parity_odd` = 1 odd. Parity settings are taken when a character is popped.
- R4: Each frame bit lasts exactly 16 `tick` pulses, counted from the cycle the character is popped.
- R5: `fifo_pop` pulses for one cycle only while the serializer is between frames, `tx_en` is 1 and `fifo_empty` is 0; exactly one pop is issued per character sent, and queued characters go out back to back.
- R6: While `tx_en` is 0 no character is popped and the pin stays 1; dropping `tx_en` during a frame lets that frame finish unchanged.
- R7: When `ovrd_en` is 1, `tx_pin` equals `ovrd_val` one cycle later, over every other source and whatever the serializer is doing.
- R8: When `ovrd_en` is 0 and `line_lpbk` is 1, `tx_pin` equals the `rx_pin` level of the cycle before, over system loopback.
- R9: When `ovrd_en` and `line_lpbk` are 0 and `sys_lpbk` is 1, `tx_pin` is held at 1 while the frame still appears on `ser_bit`.
- R10: `tx_empty` equals the value `fifo_empty` had in the previous cycle.
- R11: `tx_idle` is 1 only when the store is empty and no frame is under way; it stays 0 through the whole stop bit of the last character and rises after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick, one pulse per sixteenth of a bit |
| tx_en | input | 1 | Allows new characters to be taken |
| parity_en | input | 1 | Adds a parity bit to each frame |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| ovrd_en | input | 1 | Forces the pin to `ovrd_val` |
| ovrd_val | input | 1 | Level used under override |
| line_lpbk | input | 1 | Copies `rx_pin` to the pin |
| sys_lpbk | input | 1 | Holds the pin high; stream only on `ser_bit` |
| rx_pin | input | 1 | Incoming serial line level |
| fifo_empty | input | 1 | Character store holds nothing |
| fifo_data | input | 8 | Head character of the store |
| fifo_pop | output | 1 | Consumes the head character |
| tx_pin | output | 1 | Serial output pin, registered |
| ser_bit | output | 1 | Raw serializer stream for the local receiver |
| tx_empty | output | 1 | Registered copy of the store's empty state |
| tx_idle | output | 1 | Store empty and last frame fully sent |

## Verification
The assertions assume the store keeps `fifo_data` steady and `fifo_empty` honest, so a pop never meets an empty store, and that parity settings only change between frames. The bench models the store as a bench-owned array whose empty flag is derived from its own read and write pointers, and it changes parity settings, tick spacing and pin modes only while `tx_idle` is high or no character is waiting. Tick spacing is always a fixed period from a bench counter, so bit lengths are whole multiples of it.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } ser_state_e;

    typedef enum logic [1:0] {
        SEL_SER  = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_RX   = 2'd2,
        SEL_OVRD = 2'd3
    } pin_sel_e;

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic bit_done
);
    localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } bc_t;

    bc_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        bit_done = 1'b0;
        if (restart) begin
            nxt_d.cnt = '0;
        end else if (tick) begin
            if (cur_q.cnt == LAST) begin
                nxt_d.cnt = '0;
                bit_done  = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R4: a bit boundary is followed by at least one non-boundary cycle
    assert_bit_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done);

    // R4: the count moves only on a tick or a restart
    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cur_q.cnt));

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              bit_done,
    output logic              fifo_pop,
    output logic              restart,
    output logic              ser_line,
    output logic              tx_empty,
    output logic              tx_idle
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        ser_state_e        state;
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic              par_bit;
        logic              par_on;
        logic              empty;
        logic              idle;
    } ser_t;

    localparam ser_t RESET_VAL = '{
        state:   ST_IDLE,
        shreg:   '0,
        idx:     '0,
        par_bit: 1'b0,
        par_on:  1'b0,
        empty:   1'b1,
        idle:    1'b1
    };

    ser_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        fifo_pop = 1'b0;
        restart  = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (tx_en && !fifo_empty) begin
                    fifo_pop      = 1'b1;
                    restart       = 1'b1;
                    nxt_d.state   = ST_START;
                    nxt_d.shreg   = fifo_data;
                    nxt_d.idx     = '0;
                    nxt_d.par_bit = (^fifo_data) ^ parity_odd;
                    nxt_d.par_on  = parity_en;
                end
            end
            ST_START: begin
                if (bit_done) nxt_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (bit_done) begin
                    nxt_d.shreg = cur_q.shreg >> 1;
                    if (cur_q.idx == LAST_IDX) begin
                        nxt_d.state = cur_q.par_on ? ST_PARITY : ST_STOP;
                    end else begin
                        nxt_d.idx = cur_q.idx + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_done) nxt_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (bit_done) nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        nxt_d.empty = fifo_empty;
        nxt_d.idle  = (nxt_d.state == ST_IDLE) && fifo_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RESET_VAL;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        unique case (cur_q.state)
            ST_START:  ser_line = 1'b0;
            ST_DATA:   ser_line = cur_q.shreg[0];
            ST_PARITY: ser_line = cur_q.par_bit;
            default:   ser_line = 1'b1;
        endcase
    end

    assign tx_empty = cur_q.empty;
    assign tx_idle  = cur_q.idle;

    // R5: a pop is a single-cycle pulse
    assert_pop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R5: a pop is never issued against an empty store
    assert_pop_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R6: a disabled transmitter takes nothing
    assert_no_pop_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !fifo_pop);

    // R11: the idle flag implies a quiet, high line
    assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> ser_line);

    // R10: the empty flag follows the store one cycle late
    assert_empty_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tx_empty == $past(fifo_empty));

endmodule

// File: rtl/uart_tx_pinmux.sv
module uart_tx_pinmux
    import uart_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovrd_en,
    input  logic ovrd_val,
    input  logic line_lpbk,
    input  logic sys_lpbk,
    input  logic rx_pin,
    input  logic ser_line,
    output logic tx_pin
);
    typedef struct packed {
        logic pin;
    } mux_t;

    mux_t     cur_q, nxt_d;
    pin_sel_e sel;

    always_comb begin
        if (ovrd_en)        sel = SEL_OVRD;
        else if (line_lpbk) sel = SEL_RX;
        else if (sys_lpbk)  sel = SEL_HIGH;
        else                sel = SEL_SER;

        nxt_d = cur_q;
        unique case (sel)
            SEL_OVRD: nxt_d.pin = ovrd_val;
            SEL_RX:   nxt_d.pin = rx_pin;
            SEL_HIGH: nxt_d.pin = 1'b1;
            default:  nxt_d.pin = ser_line;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{pin: 1'b1};
        else        cur_q <= nxt_d;
    end

    assign tx_pin = cur_q.pin;

    // R7: override wins and lands one cycle later
    assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovrd_en |=> tx_pin == $past(ovrd_val));

    // R8: line loopback forwards the receive level
    assert_line_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovrd_en && line_lpbk) |=> tx_pin == $past(rx_pin));

    // R9: system loopback parks the pin high
    assert_sys_loop_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovrd_en && !line_lpbk && sys_lpbk) |=> tx_pin);

    // R2: in normal mode the pin follows the serializer
    assert_normal_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovrd_en && !line_lpbk && !sys_lpbk) |=> tx_pin == $past(ser_line));

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              ovrd_en,
    input  logic              ovrd_val,
    input  logic              line_lpbk,
    input  logic              sys_lpbk,
    input  logic              rx_pin,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              tx_pin,
    output logic              ser_bit,
    output logic              tx_empty,
    output logic              tx_idle
);
    logic bit_done;
    logic restart;
    logic ser_line;

    uart_tx_bitclk #(.OSR(OSR)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .bit_done (bit_done)
    );

    uart_tx_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .bit_done   (bit_done),
        .fifo_pop   (fifo_pop),
        .restart    (restart),
        .ser_line   (ser_line),
        .tx_empty   (tx_empty),
        .tx_idle    (tx_idle)
    );

    uart_tx_pinmux u_pinmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovrd_en   (ovrd_en),
        .ovrd_val  (ovrd_val),
        .line_lpbk (line_lpbk),
        .sys_lpbk  (sys_lpbk),
        .rx_pin    (rx_pin),
        .ser_line  (ser_line),
        .tx_pin    (tx_pin)
    );

    assign ser_bit = ser_line;

endmodule

// File: tb/uart_tx_path_bench.sv
module uart_tx_path_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       tx_en = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
    logic       ovrd_en = 1'b0, ovrd_val = 1'b0;
    logic       line_lpbk = 1'b0, sys_lpbk = 1'b0, rx_pin = 1'b1;
    logic       fifo_empty, fifo_pop, tx_pin, ser_bit, tx_empty, tx_idle;
    logic [7:0] fifo_data;

    int checks = 0, fails = 0;
    int tp = 1, tcnt = 0;
    logic [7:0] fmem [0:511];
    int wr_ptr = 0, rd_ptr = 0, pops = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) tcnt <= (tcnt + 1 >= tp) ? 0 : tcnt + 1;
    assign tick       = (tcnt == 0);
    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_data  = fmem[rd_ptr & 511];

    always @(posedge clk) if (rst_n && fifo_pop) begin
        rd_ptr <= rd_ptr + 1;
        pops   <= pops + 1;
    end

    uart_tx_path u_uart_tx_path (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
        .parity_en(parity_en), .parity_odd(parity_odd),
        .ovrd_en(ovrd_en), .ovrd_val(ovrd_val), .line_lpbk(line_lpbk),
        .sys_lpbk(sys_lpbk), .rx_pin(rx_pin), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .tx_pin(tx_pin),
        .ser_bit(ser_bit), .tx_empty(tx_empty), .tx_idle(tx_idle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        fmem[wr_ptr & 511] = d;
        wr_ptr++;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Decode one frame from tx_pin or ser_bit, sampling mid-bit.
    task automatic recv(input bit use_ser, input bit with_par, input bit pin_hi_chk,
                        output logic [7:0] d, output logic p, output bit ok);
        int  guard = 0;
        logic s;
        ok = 1; d = '0; p = 1'b0;
        while ((use_ser ? ser_bit : tx_pin) !== 1'b0 && guard < 3000 * tp) begin
            @(negedge clk); guard++;
        end
        if (guard >= 3000 * tp) begin ok = 0; return; end
        repeat (8 * tp) @(negedge clk);
        if ((use_ser ? ser_bit : tx_pin) !== 1'b0) ok = 0;
        if (pin_hi_chk && tx_pin !== 1'b1) ok = 0;
        for (int b = 0; b < 8; b++) begin
            repeat (16 * tp) @(negedge clk);
            s = use_ser ? ser_bit : tx_pin;
            d[b] = s;
            if (pin_hi_chk && tx_pin !== 1'b1) ok = 0;
        end
        if (with_par) begin
            repeat (16 * tp) @(negedge clk);
            p = use_ser ? ser_bit : tx_pin;
        end
        repeat (16 * tp) @(negedge clk);
        if ((use_ser ? ser_bit : tx_pin) !== 1'b1) ok = 0;
    endtask

    function automatic logic exp_par(input logic [7:0] v, input logic odd);
        return logic'($countones(v) % 2) ^ odd;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        logic [7:0] d;
        logic       p;
        bit         ok;
        int         n, lows, p0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_pin === 1'b1, "R1 tx_pin", tx_pin, 1);
        check(tx_idle === 1'b1, "R1 tx_idle", tx_idle, 1);
        check(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
        check(fifo_pop === 1'b0, "R1 fifo_pop", fifo_pop, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R5: all 256 characters back to back, no parity
        for (int i = 0; i < 256; i++) push(8'(i));
        tx_en = 1'b1;
        for (int i = 0; i < 256; i++) begin
            recv(0, 0, 0, d, p, ok);
            check(ok && d == 8'(i), "R2 frame data", int'(d), i);
            if (i == 255) begin
                // R11: still busy in the middle of the last stop bit
                check(tx_idle === 1'b0, "R11 idle during stop", tx_idle, 0);
            end
        end
        repeat (16) @(negedge clk);
        check(tx_idle === 1'b1, "R11 idle after stop", tx_idle, 1);
        check(pops == 256, "R5 pop count", pops, 256);

        // R3: even parity on even values, odd parity on odd values
        for (int odd = 0; odd < 2; odd++) begin
            parity_en  = 1'b1;
            parity_odd = logic'(odd);
            for (int i = 0; i < 128; i++) push(8'(2 * i + odd));
            for (int i = 0; i < 128; i++) begin
                recv(0, 1, 0, d, p, ok);
                check(ok && d == 8'(2 * i + odd), "R3 parity frame data", int'(d), 2 * i + odd);
                check(p === exp_par(8'(2 * i + odd), logic'(odd)), "R3 parity bit",
                      int'(p), int'(exp_par(8'(2 * i + odd), logic'(odd))));
            end
            repeat (16) @(negedge clk);
        end
        parity_en = 1'b0; parity_odd = 1'b0;

        // R4: bit length with a tick every third cycle, data 0x05
        tp = 3;
        repeat (4) @(negedge clk);
        push(8'h05);
        n = 0;
        while (tx_pin !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
        lows = 0;
        while (tx_pin === 1'b0 && lows < 200) begin @(negedge clk); lows++; end
        check(lows >= 15 * tp + 1 && lows <= 16 * tp, "R4 start bit length", lows, 16 * tp);
        n = 0;
        while (tx_pin === 1'b1 && n < 200) begin @(negedge clk); n++; end
        check(n == 16 * tp, "R4 data bit0 length", n, 16 * tp);
        n = 0;
        while (tx_pin === 1'b0 && n < 200) begin @(negedge clk); n++; end
        check(n == 16 * tp, "R4 data bit1 length", n, 16 * tp);
        while (tx_idle !== 1'b1) @(negedge clk);
        tp = 1;
        repeat (4) @(negedge clk);

        // R6/R10: disabled transmitter holds the character
        tx_en = 1'b0;
        p0 = pops;
        push(8'h3C);
        @(negedge clk);
        check(tx_empty === 1'b0, "R10 empty follows store", tx_empty, 0);
        check(tx_idle === 1'b0, "R11 not idle with data queued", tx_idle, 0);
        lows = 0;
        repeat (300) begin @(negedge clk); if (tx_pin !== 1'b1) lows++; end
        check(lows == 0, "R6 pin high while disabled", lows, 0);
        check(pops == p0, "R6 no pop while disabled", pops, p0);
        tx_en = 1'b1;
        recv(0, 0, 0, d, p, ok);
        check(ok && d == 8'h3C, "R6 frame after enable", int'(d), 'h3C);
        repeat (16) @(negedge clk);
        check(tx_empty === 1'b1, "R10 empty after drain", tx_empty, 1);

        // R6: dropping enable mid-frame lets the frame finish
        push(8'hA5); push(8'h5A);
        p0 = pops;
        while (pops == p0) @(negedge clk);
        tx_en = 1'b0;
        recv(0, 0, 0, d, p, ok);
        check(ok && d == 8'hA5, "R6 frame completes", int'(d), 'hA5);
        lows = 0;
        repeat (400) begin @(negedge clk); if (tx_pin !== 1'b1) lows++; end
        check(lows == 0 && pops == p0 + 1, "R6 next not taken", pops, p0 + 1);
        tx_en = 1'b1;
        recv(0, 0, 0, d, p, ok);
        check(ok && d == 8'h5A, "R6 drained frame", int'(d), 'h5A);
        repeat (16) @(negedge clk);

        // R7: override levels and priority
        ovrd_en = 1'b1; ovrd_val = 1'b0;
        @(negedge clk);
        check(tx_pin === 1'b0, "R7 override low", tx_pin, 0);
        ovrd_val = 1'b1; line_lpbk = 1'b1; rx_pin = 1'b0;
        @(negedge clk);
        check(tx_pin === 1'b1, "R7 override over line loopback", tx_pin, 1);
        line_lpbk = 1'b0; rx_pin = 1'b1;
        push(8'h00);
        lows = 0;
        repeat (120) begin @(negedge clk); if (tx_pin !== 1'b1) lows++; end
        check(lows == 0, "R7 override during frame", lows, 0);
        check(ser_bit === 1'b0, "R7 serializer still running", ser_bit, 0);
        while (tx_idle !== 1'b1) @(negedge clk);
        ovrd_en = 1'b0;
        repeat (2) @(negedge clk);

        // R8: line loopback follows rx, over system loopback
        line_lpbk = 1'b1; sys_lpbk = 1'b1;
        lows = 0;
        for (int k = 0; k < 40; k++) begin
            rx_pin = logic'((k * 7 / 3) % 2);
            @(negedge clk);
            if (tx_pin !== logic'((k * 7 / 3) % 2)) lows++;
        end
        check(lows == 0, "R8 line loopback mismatches", lows, 0);
        line_lpbk = 1'b0; rx_pin = 1'b1;
        @(negedge clk);

        // R9: system loopback, odd parity, stream on ser_bit
        parity_en = 1'b1; parity_odd = 1'b1;
        push(8'h96);
        recv(1, 1, 1, d, p, ok);
        check(ok && d == 8'h96, "R9 internal stream data, pin high", int'(d), 'h96);
        check(p === exp_par(8'h96, 1'b1), "R9 internal parity", int'(p), int'(exp_par(8'h96, 1'b1)));
        repeat (16) @(negedge clk);
        check(tx_pin === 1'b1 && tx_idle === 1'b1, "R9 quiet after frame", tx_pin, 1);

        done = 1;
        report();
    end
endmodule